// File: doc/BRIEF.md
# Multi-Channel Circular Command Queue with Debug Peek

This block holds the command queues of several channels inside one shared word memory. Each channel owns a window of that memory, described by a base address and a limit address (both inclusive). Every channel keeps its own read and write pointers. When a pointer sits on the limit of its window, its next step takes it back to the base of that window, not to address zero. Producers push words into a channel, and consumers pop them from that channel in first-in, first-out order.

A debug peek port sits beside the data path. Writing its control register with the enable bit set selects one channel and one memory address. From the next cycle, the peek outputs show the selected channel's current read and write pointers, together with the memory word at the chosen address. Peeking never moves a pointer and never changes a memory word, so a debugger can inspect a stuck queue in place. Writing the control register with the enable bit clear turns peeking off, and all peek outputs then read zero.

After reset, channel i owns the window from i*16 to i*16+15 of the 64-word memory. Software can move any channel's window with a configuration write.

Top module: `cmdq_ring`

## Requirements
- R1: After reset, every channel is empty, not full, and its overflow and underflow flags are clear. Channel i has both pointers at its default base i*16 and its limit at i*16+15. The peek port starts disabled, with all of its outputs at zero.
- R2: An accepted push writes `push_data` at the channel's write pointer and advances that pointer. An accepted pop raises `pop_valid` in the next cycle, with `pop_data` holding the word at the read pointer. Words leave a channel in the order they entered it.
- R3: A pointer equal to its channel's limit advances to that channel's base. Any other pointer advances by one.
- R4: A channel reports empty when its read pointer equals its write pointer. It reports full when advancing its write pointer would make it equal to its read pointer, so a window holds limit minus base words.
- R5: A push into a full channel is ignored: no pointer moves and no memory word changes. The push sets that channel's overflow flag, which stays set until reset.
- R6: A pop from an empty channel is ignored: `pop_valid` stays low and no pointer moves. The pop sets that channel's underflow flag, which stays set until reset.
- R7: A configuration write loads a new base and limit for one channel and places both of its pointers at the new base, which leaves the channel empty. In the same cycle, a push or pop on that same channel is dropped without setting any flag.
- R8: With peek enabled, `peek_rd_ptr` and `peek_wr_ptr` show the current pointers of the selected channel.
- R9: With peek enabled, `peek_data` shows the memory word at `peek_addr` (an absolute memory address) one cycle after the control write. Peeking leaves every pointer and every memory word unchanged.
- R10: After a control write with `peek_en` low, `peek_rd_ptr`, `peek_wr_ptr` and `peek_data` all read zero.
- R11: Traffic on one channel never changes the pointers, flags or contents of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load a new window into one channel |
| cfg_ch | input | 2 | Channel the window write targets |
| cfg_base | input | 6 | New base address, inclusive |
| cfg_limit | input | 6 | New limit address, inclusive |
| push_valid | input | 1 | Push request |
| push_ch | input | 2 | Channel to push into |
| push_data | input | 32 | Word to push |
| pop_req | input | 1 | Pop request |
| pop_ch | input | 2 | Channel to pop from |
| pop_valid | output | 1 | High when `pop_data` holds a popped word |
| pop_data | output | 32 | Popped word |
| chan_empty | output | 4 | Empty flag, one bit per channel |
| chan_full | output | 4 | Full flag, one bit per channel |
| ovf_flag | output | 4 | Sticky overflow flag, one bit per channel |
| udf_flag | output | 4 | Sticky underflow flag, one bit per channel |
| peek_we | input | 1 | Write the peek control register |
| peek_en | input | 1 | Enable bit of the peek control write |
| peek_ch | input | 2 | Channel whose pointers are peeked |
| peek_addr | input | 6 | Memory address whose word is peeked |
| peek_rd_ptr | output | 6 | Read pointer of the peeked channel |
| peek_wr_ptr | output | 6 | Write pointer of the peeked channel |
| peek_data | output | 32 | Word at the peeked address |

## Verification
A pointer that wraps to the wrong place shows up in the first pop that crosses the limit: it returns a stale or foreign word. Through the peek outputs, the same fault shows as a pointer value outside the window, one cycle after a peek write. A wrong full or empty decision shows in the very next cycle, as a flag mismatch or a sticky error flag that should not be set. A dropped word appears only later, as a misordered pop. For that reason, the full and empty flags of every channel are compared with a reference model after each cycle, and every popped word is compared as well, under random traffic that also reconfigures the windows.

// File: rtl/cq_pkg.sv
`timescale 1ns/1ps
package cq_pkg;
    localparam int CQ_CHANNELS = 4;
    localparam int CQ_DATA_W   = 32;
    localparam int CQ_ADDR_W   = 6;
    localparam int CQ_WORDS    = 1 << CQ_ADDR_W;
    localparam int CQ_CH_W     = (CQ_CHANNELS > 1) ? $clog2(CQ_CHANNELS) : 1;
    localparam int CQ_SEG      = CQ_WORDS / CQ_CHANNELS;

    typedef logic [CQ_ADDR_W-1:0] ptr_t;
    typedef logic [CQ_DATA_W-1:0] word_t;
    typedef logic [CQ_CH_W-1:0]   chan_t;

    // Inclusive address window owned by one channel.
    typedef struct packed {
        ptr_t base;
        ptr_t limit;
    } window_t;

    typedef struct packed {
        logic en;
        chan_t ch;
        ptr_t addr;
    } peek_ctrl_t;

    typedef struct packed {
        logic empty;
        logic full;
        logic ovf;
        logic udf;
    } chan_stat_t;

    // Step a pointer inside its window: from the limit back to the base.
    function automatic ptr_t ring_next(ptr_t p, window_t w);
        return (p == w.limit) ? w.base : p + ptr_t'(1);
    endfunction

    function automatic window_t default_window(int idx);
        window_t w;
        w.base  = ptr_t'(idx * CQ_SEG);
        w.limit = ptr_t'(idx * CQ_SEG + CQ_SEG - 1);
        return w;
    endfunction
endpackage

// File: rtl/cq_chan_ptr.sv
`timescale 1ns/1ps
module cq_chan_ptr
    import cq_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  window_t    cfg_win,
    input  logic       push_req,
    input  logic       pop_req,
    output ptr_t       rd_ptr,
    output ptr_t       wr_ptr,
    output chan_stat_t stat,
    output logic       push_ok,
    output logic       pop_ok
);
    localparam window_t RST_WIN = default_window(IDX);

    window_t win;
    logic    ovf_q, udf_q;
    logic    is_empty, is_full;

    assign is_empty = (rd_ptr == wr_ptr);
    assign is_full  = (ring_next(wr_ptr, win) == rd_ptr);
    assign push_ok  = push_req && !is_full;
    assign pop_ok   = pop_req && !is_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            win    <= RST_WIN;
            rd_ptr <= RST_WIN.base;
            wr_ptr <= RST_WIN.base;
            ovf_q  <= 1'b0;
            udf_q  <= 1'b0;
        end else if (cfg_we) begin
            win    <= cfg_win;
            rd_ptr <= cfg_win.base;
            wr_ptr <= cfg_win.base;
        end else begin
            if (push_ok) wr_ptr <= ring_next(wr_ptr, win);
            if (pop_ok)  rd_ptr <= ring_next(rd_ptr, win);
            if (push_req && is_full)  ovf_q <= 1'b1;
            if (pop_req  && is_empty) udf_q <= 1'b1;
        end
    end

    always_comb begin
        stat.empty = is_empty;
        stat.full  = is_full;
        stat.ovf   = ovf_q;
        stat.udf   = udf_q;
    end

    assert_wr_in_window_R3: assert property (@(posedge clk) disable iff (rst)
        (win.base <= win.limit) |-> (wr_ptr >= win.base && wr_ptr <= win.limit));
    assert_rd_in_window_R3: assert property (@(posedge clk) disable iff (rst)
        (win.base <= win.limit) |-> (rd_ptr >= win.base && rd_ptr <= win.limit));
    assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (push_ok && !cfg_we && wr_ptr == win.limit) |=> (wr_ptr == win.base));
    assert_no_push_when_full_R5: assert property (@(posedge clk) disable iff (rst)
        (push_req && is_full && !cfg_we) |=> ($stable(wr_ptr) && ovf_q));
    assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        ovf_q |=> ovf_q);
    assert_no_pop_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
        (pop_req && is_empty && !cfg_we) |=> ($stable(rd_ptr) && udf_q));
    assert_udf_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        udf_q |=> udf_q);
    assert_cfg_empties_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (rd_ptr == wr_ptr));
endmodule

// File: rtl/cq_store.sv
`timescale 1ns/1ps
module cq_store
    import cq_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  ptr_t  waddr,
    input  word_t wdata,
    input  logic  re,
    input  ptr_t  raddr,
    output word_t rdata,
    output logic  rvalid,
    input  ptr_t  peek_addr,
    output word_t peek_word
);
    word_t mem [CQ_WORDS];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= re;
            if (re) rdata <= mem[raddr];
        end
    end

    // Side read port: no state, so it cannot disturb the queue.
    assign peek_word = mem[peek_addr];
endmodule

// File: rtl/cq_peek.sv
`timescale 1ns/1ps
module cq_peek
    import cq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ctrl_we,
    input  peek_ctrl_t ctrl_in,
    input  ptr_t       rd_ptrs [CQ_CHANNELS],
    input  ptr_t       wr_ptrs [CQ_CHANNELS],
    output ptr_t       mem_addr,
    input  word_t      mem_word,
    output ptr_t       out_rd,
    output ptr_t       out_wr,
    output word_t      out_data
);
    peek_ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst)          ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= ctrl_in;
    end

    assign mem_addr = ctrl_q.addr;

    always_comb begin
        if (ctrl_q.en) begin
            out_rd   = rd_ptrs[ctrl_q.ch];
            out_wr   = wr_ptrs[ctrl_q.ch];
            out_data = mem_word;
        end else begin
            out_rd   = '0;
            out_wr   = '0;
            out_data = '0;
        end
    end
endmodule

// File: rtl/cmdq_ring.sv
`timescale 1ns/1ps
module cmdq_ring
    import cq_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   cfg_we,
    input  logic [CQ_CH_W-1:0]     cfg_ch,
    input  logic [CQ_ADDR_W-1:0]   cfg_base,
    input  logic [CQ_ADDR_W-1:0]   cfg_limit,
    input  logic                   push_valid,
    input  logic [CQ_CH_W-1:0]     push_ch,
    input  logic [CQ_DATA_W-1:0]   push_data,
    input  logic                   pop_req,
    input  logic [CQ_CH_W-1:0]     pop_ch,
    output logic                   pop_valid,
    output logic [CQ_DATA_W-1:0]   pop_data,
    output logic [CQ_CHANNELS-1:0] chan_empty,
    output logic [CQ_CHANNELS-1:0] chan_full,
    output logic [CQ_CHANNELS-1:0] ovf_flag,
    output logic [CQ_CHANNELS-1:0] udf_flag,
    input  logic                   peek_we,
    input  logic                   peek_en,
    input  logic [CQ_CH_W-1:0]     peek_ch,
    input  logic [CQ_ADDR_W-1:0]   peek_addr,
    output logic [CQ_ADDR_W-1:0]   peek_rd_ptr,
    output logic [CQ_ADDR_W-1:0]   peek_wr_ptr,
    output logic [CQ_DATA_W-1:0]   peek_data
);
    ptr_t                   rd_ptrs [CQ_CHANNELS];
    ptr_t                   wr_ptrs [CQ_CHANNELS];
    logic [CQ_CHANNELS-1:0] push_ok_v, pop_ok_v;
    window_t                cfg_win;
    peek_ctrl_t             peek_ctrl;
    ptr_t                   peek_mem_addr;
    word_t                  peek_mem_word;

    assign cfg_win.base  = cfg_base;
    assign cfg_win.limit = cfg_limit;

    for (genvar i = 0; i < CQ_CHANNELS; i++) begin : g_chan
        logic       cfg_hit;
        chan_stat_t st;

        // A window load wins over traffic on the same channel.
        assign cfg_hit = cfg_we && (cfg_ch == chan_t'(i));

        cq_chan_ptr #(.IDX(i)) u_ptr (
            .clk      (clk),
            .rst      (rst),
            .cfg_we   (cfg_hit),
            .cfg_win  (cfg_win),
            .push_req (push_valid && push_ch == chan_t'(i) && !cfg_hit),
            .pop_req  (pop_req && pop_ch == chan_t'(i) && !cfg_hit),
            .rd_ptr   (rd_ptrs[i]),
            .wr_ptr   (wr_ptrs[i]),
            .stat     (st),
            .push_ok  (push_ok_v[i]),
            .pop_ok   (pop_ok_v[i])
        );

        assign chan_empty[i] = st.empty;
        assign chan_full[i]  = st.full;
        assign ovf_flag[i]   = st.ovf;
        assign udf_flag[i]   = st.udf;
    end

    cq_store u_store (
        .clk       (clk),
        .rst       (rst),
        .we        (|push_ok_v),
        .waddr     (wr_ptrs[push_ch]),
        .wdata     (push_data),
        .re        (|pop_ok_v),
        .raddr     (rd_ptrs[pop_ch]),
        .rdata     (pop_data),
        .rvalid    (pop_valid),
        .peek_addr (peek_mem_addr),
        .peek_word (peek_mem_word)
    );

    assign peek_ctrl.en   = peek_en;
    assign peek_ctrl.ch   = peek_ch;
    assign peek_ctrl.addr = peek_addr;

    cq_peek u_peek (
        .clk      (clk),
        .rst      (rst),
        .ctrl_we  (peek_we),
        .ctrl_in  (peek_ctrl),
        .rd_ptrs  (rd_ptrs),
        .wr_ptrs  (wr_ptrs),
        .mem_addr (peek_mem_addr),
        .mem_word (peek_mem_word),
        .out_rd   (peek_rd_ptr),
        .out_wr   (peek_wr_ptr),
        .out_data (peek_data)
    );

    assert_pop_valid_source_R2: assert property (@(posedge clk) disable iff (rst)
        pop_valid |-> $past(pop_req));
    assert_empty_pop_silent_R6: assert property (@(posedge clk) disable iff (rst)
        (pop_req && chan_empty[pop_ch] && !cfg_we) |=> !pop_valid);
    assert_peek_off_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (peek_we && !peek_en) |=> (peek_data == '0 && peek_rd_ptr == '0 && peek_wr_ptr == '0));
    assert_onehot_push_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(push_ok_v));
endmodule

// File: tb/cmdq_ring_test.sv
`timescale 1ns/1ps
module cmdq_ring_test;
    import cq_pkg::*;

    logic clk = 1'b0, rst = 1'b1;
    logic cfg_we = 0; logic [CQ_CH_W-1:0] cfg_ch = 0;
    logic [CQ_ADDR_W-1:0] cfg_base = 0, cfg_limit = 0;
    logic push_valid = 0; logic [CQ_CH_W-1:0] push_ch = 0; logic [CQ_DATA_W-1:0] push_data = 0;
    logic pop_req = 0; logic [CQ_CH_W-1:0] pop_ch = 0;
    logic pop_valid; logic [CQ_DATA_W-1:0] pop_data;
    logic [CQ_CHANNELS-1:0] chan_empty, chan_full, ovf_flag, udf_flag;
    logic peek_we = 0, peek_en = 0; logic [CQ_CH_W-1:0] peek_ch = 0;
    logic [CQ_ADDR_W-1:0] peek_addr = 0;
    logic [CQ_ADDR_W-1:0] peek_rd_ptr, peek_wr_ptr;
    logic [CQ_DATA_W-1:0] peek_data;

    always #2 clk = ~clk;

    cmdq_ring uut (.*);

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    int m_rd[CQ_CHANNELS], m_wr[CQ_CHANNELS], m_base[CQ_CHANNELS], m_lim[CQ_CHANNELS];
    bit m_ovf[CQ_CHANNELS], m_udf[CQ_CHANNELS];
    logic [CQ_DATA_W-1:0] m_mem[CQ_WORDS];
    bit m_valid[CQ_WORDS];

    function automatic int nxt(int p, int c);
        return (p == m_lim[c]) ? m_base[c] : p + 1;
    endfunction

    task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_flags();
        for (int c = 0; c < CQ_CHANNELS; c++) begin
            bit e = (m_rd[c] == m_wr[c]);
            bit f = (nxt(m_wr[c], c) == m_rd[c]);
            check(chan_empty[c] == e, "R4 empty (R11 per channel)", 64'(chan_empty[c]), 64'(e));
            check(chan_full[c] == f, "R4 full (R11 per channel)", 64'(chan_full[c]), 64'(f));
            check(ovf_flag[c] == m_ovf[c], "R5 overflow flag", 64'(ovf_flag[c]), 64'(m_ovf[c]));
            check(udf_flag[c] == m_udf[c], "R6 underflow flag", 64'(udf_flag[c]), 64'(m_udf[c]));
        end
    endtask

    task automatic cycle(bit pv, int pc, logic [CQ_DATA_W-1:0] pd, bit rv, int rc);
        bit p_ok, r_ok;
        logic [CQ_DATA_W-1:0] exp_d;
        push_valid = pv; push_ch = CQ_CH_W'(pc); push_data = pd;
        pop_req = rv; pop_ch = CQ_CH_W'(rc);
        p_ok = pv && (nxt(m_wr[pc], pc) != m_rd[pc]);
        r_ok = rv && (m_rd[rc] != m_wr[rc]);
        exp_d = r_ok ? m_mem[m_rd[rc]] : '0;
        @(posedge clk);
        if (p_ok) begin
            m_mem[m_wr[pc]] = pd; m_valid[m_wr[pc]] = 1; m_wr[pc] = nxt(m_wr[pc], pc);
        end else if (pv) m_ovf[pc] = 1;
        if (r_ok) m_rd[rc] = nxt(m_rd[rc], rc);
        else if (rv) m_udf[rc] = 1;
        @(negedge clk);
        push_valid = 0; pop_req = 0;
        check(pop_valid == r_ok, (rv && !r_ok) ? "R6 pop on empty" : "R2 pop valid",
              64'(pop_valid), 64'(r_ok));
        if (r_ok) check(pop_data == exp_d, "R2 pop order/data", 64'(pop_data), 64'(exp_d));
        check_flags();
    endtask

    task automatic configure(int c, int b, int l);
        cfg_we = 1; cfg_ch = CQ_CH_W'(c); cfg_base = CQ_ADDR_W'(b); cfg_limit = CQ_ADDR_W'(l);
        @(posedge clk);
        m_base[c] = b; m_lim[c] = l; m_rd[c] = b; m_wr[c] = b;
        @(negedge clk);
        cfg_we = 0;
        check(chan_empty[c] == 1'b1, "R7 window load empties channel", 64'(chan_empty[c]), 64'd1);
        check_flags();
    endtask

    task automatic peek(bit en, int c, int a, string req);
        peek_we = 1; peek_en = en; peek_ch = CQ_CH_W'(c); peek_addr = CQ_ADDR_W'(a);
        @(posedge clk);
        @(negedge clk);
        peek_we = 0;
        if (en) begin
            check(peek_rd_ptr == CQ_ADDR_W'(m_rd[c]), {req, " R8 read pointer"}, 64'(peek_rd_ptr), 64'(m_rd[c]));
            check(peek_wr_ptr == CQ_ADDR_W'(m_wr[c]), {req, " R8 write pointer"}, 64'(peek_wr_ptr), 64'(m_wr[c]));
            if (m_valid[a])
                check(peek_data == m_mem[a], {req, " R9 peek word"}, 64'(peek_data), 64'(m_mem[a]));
        end else begin
            check(peek_rd_ptr == '0 && peek_wr_ptr == '0, "R10 pointers zero when disabled",
                  64'({peek_rd_ptr, peek_wr_ptr}), 64'd0);
            check(peek_data == '0, "R10 data zero when disabled", 64'(peek_data), 64'd0);
        end
        check_flags(); // R9: peeking moved nothing
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < CQ_CHANNELS; c++) begin
            m_base[c] = c * CQ_SEG; m_lim[c] = c * CQ_SEG + CQ_SEG - 1;
            m_rd[c] = m_base[c]; m_wr[c] = m_base[c]; m_ovf[c] = 0; m_udf[c] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state
        check(peek_data == '0 && peek_rd_ptr == '0 && peek_wr_ptr == '0, "R1 peek idle after reset",
              64'(peek_data), 64'd0);
        check(pop_valid == 1'b0, "R1 no pop after reset", 64'(pop_valid), 64'd0);
        check_flags();
        for (int c = 0; c < CQ_CHANNELS; c++) peek(1, c, 0, "R1 default base");

        // R2: FIFO order on channel 0
        cycle(1, 0, 32'hA0A0_0001, 0, 0);
        cycle(1, 0, 32'hA0A0_0002, 0, 0);
        cycle(1, 0, 32'hA0A0_0003, 1, 0);
        cycle(0, 0, 0, 1, 0);
        cycle(0, 0, 0, 1, 0);
        peek(1, 0, 1, "R2");

        // R3/R4/R5: small window on channel 1
        configure(1, 20, 23);
        cycle(1, 1, 32'h1111_0001, 0, 0);
        cycle(1, 1, 32'h1111_0002, 0, 0);
        cycle(1, 1, 32'h1111_0003, 0, 0);
        check(chan_full[1] == 1'b1, "R4 three words fill window 20..23", 64'(chan_full[1]), 64'd1);
        cycle(1, 1, 32'hDEAD_BEEF, 0, 0);          // R5 dropped push
        peek(1, 1, 23, "R5 full push dropped");
        cycle(0, 0, 0, 1, 1);
        cycle(1, 1, 32'h1111_0004, 0, 0);          // write pointer wraps 23 -> 20
        peek(1, 1, 23, "R3 wrap");
        check(peek_wr_ptr == 6'd20, "R3 write pointer wrapped to base", 64'(peek_wr_ptr), 64'd20);
        repeat (3) cycle(0, 0, 0, 1, 1);
        check(m_rd[1] == 20, "R3 read pointer wrapped to base", 64'(m_rd[1]), 64'd20);

        // R6: empty pop
        cycle(0, 0, 0, 1, 2);
        // R7: push on channel being reconfigured is dropped
        cfg_we = 1; cfg_ch = 2'd3; cfg_base = 6'd50; cfg_limit = 6'd55;
        push_valid = 1; push_ch = 2'd3; push_data = 32'h7777_7777;
        @(posedge clk);
        m_base[3] = 50; m_lim[3] = 55; m_rd[3] = 50; m_wr[3] = 50;
        @(negedge clk);
        cfg_we = 0; push_valid = 0;
        check(chan_empty[3] == 1'b1, "R7 same-cycle push dropped", 64'(chan_empty[3]), 64'd1);
        check_flags();
        // R10
        peek(0, 1, 20, "R10");

        // Random traffic
        for (int it = 0; it < 3000; it++) begin
            int op = $urandom % 8;
            int c1 = $urandom % CQ_CHANNELS;
            int c2 = $urandom % CQ_CHANNELS;
            if (it % 500 == 499) begin
                int b = c1 * CQ_SEG + ($urandom % 4);
                configure(c1, b, b + 2 + ($urandom % 10));
            end
            case (op)
                0, 1, 2: cycle(1, c1, $urandom, 0, 0);
                3, 4:    cycle(0, 0, 0, 1, c1);
                5:       cycle(1, c1, $urandom, 1, c2);
                6:       peek(1, c1, $urandom % CQ_WORDS, "random");
                default: cycle(0, 0, 0, 0, 0);
            endcase
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule